// File: doc/BRIEF.md
# Memory-Mapped 16x16 Multiply-Accumulate Unit

This block sits on a simple word-wide register bus and multiplies two 16-bit operands. It can run in four modes: unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. The host picks the mode by choosing which of four first-operand offsets it writes. The value written is latched as the first operand. Writing the second operand runs the selected operation in that same bus cycle. The host then reads back the low and high result words and a sign word. There is no start bit and no busy state.

The mode register is the block's state machine. Its four states are `MODE_UMUL`, `MODE_SMUL`, `MODE_UMAC` and `MODE_SMAC`. Reset enters `MODE_UMUL`. A write to a first-operand offset moves the machine to the state named by that offset; any other write leaves it where it is. A plain multiply replaces the product register and zeroes the accumulator. An accumulate adds into the accumulator and zeroes the product register. Reads are registered: the data appears on `rd_data` one cycle after the read strobe and stays there until the next read.

Top module: `mac_periph`

## Requirements
- R1: A write to offset 0x130, 0x132, 0x134 or 0x136 latches `wr_data` as operand 1 and selects unsigned multiply, signed multiply, unsigned accumulate or signed accumulate respectively.
- R2: A write to offset 0x138 uses `wr_data` as operand 2 and performs the selected operation in that cycle, so a read issued in the following cycle returns the new result.
- R3: In the two signed modes, both operands are taken as two's-complement 16-bit values. In the unsigned modes, both are zero-extended.
- R4: A multiply (either signedness) stores the 32-bit product in the product register and clears the accumulator.
- R5: An accumulate adds the 32-bit product to the accumulator, modulo 2^32, and clears the product register.
- R6: A read strobe at offset 0x13A returns bits 15:0 and at 0x13C bits 31:16 of the product register in multiply modes, or of the accumulator in accumulate modes. The data is valid on `rd_data` in the cycle after the strobe and is held until the next strobe.
- R7: A read at offset 0x13E returns 0xFFFF when the mode is signed and bit 31 of the value selected under R6 is set, and 0x0000 otherwise.
- R8: Operand 1 and the mode persist, so each further write to 0x138 repeats the operation with the held operand 1.
- R9: Reset clears operand 1, the product register, the accumulator and `rd_data`, and selects unsigned multiply.
- R10: Writes to any offset other than 0x130 through 0x138 change nothing. Reads of any offset other than 0x13A, 0x13C and 0x13E return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| addr | input | 9 | Register byte offset |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that `wr_en` and `rd_en` are clean single-cycle levels sampled at the rising edge. They also assume that every access is a whole word at an even offset. The stimulus drives all bus inputs only on falling edges and uses only even offsets. It mixes directed sequences with random reads and writes, both inside and outside the register window. Simultaneous read and write strobes are allowed: the read returns the value from before the write.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        MODE_UMUL = 2'd0,
        MODE_SMUL = 2'd1,
        MODE_UMAC = 2'd2,
        MODE_SMAC = 2'd3
    } mac_mode_t;

    localparam int unsigned OFS_LOAD_UMUL = 32'h130;
    localparam int unsigned OFS_LOAD_SMUL = 32'h132;
    localparam int unsigned OFS_LOAD_UMAC = 32'h134;
    localparam int unsigned OFS_LOAD_SMAC = 32'h136;
    localparam int unsigned OFS_TRIGGER   = 32'h138;
    localparam int unsigned OFS_RES_LO    = 32'h13A;
    localparam int unsigned OFS_RES_HI    = 32'h13C;
    localparam int unsigned OFS_SIGN      = 32'h13E;
endpackage

// File: rtl/mac_mode_ctl.sv
module mac_mode_ctl
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output mac_mode_t     mode,
    output logic [DW-1:0] op1,
    output logic          fire,
    output logic          is_signed,
    output logic          is_accum
);
    mac_mode_t     nxt_mode;
    logic          load_hit;

    always_comb begin
        nxt_mode = mode;
        load_hit = 1'b0;
        if (wr_en) begin
            if (addr == AW'(OFS_LOAD_UMUL)) begin
                nxt_mode = MODE_UMUL;
                load_hit = 1'b1;
            end else if (addr == AW'(OFS_LOAD_SMUL)) begin
                nxt_mode = MODE_SMUL;
                load_hit = 1'b1;
            end else if (addr == AW'(OFS_LOAD_UMAC)) begin
                nxt_mode = MODE_UMAC;
                load_hit = 1'b1;
            end else if (addr == AW'(OFS_LOAD_SMAC)) begin
                nxt_mode = MODE_SMAC;
                load_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MODE_UMUL;
            op1  <= '0;
        end else begin
            mode <= nxt_mode;
            if (load_hit) op1 <= wr_data;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_UMUL: begin is_signed = 1'b0; is_accum = 1'b0; end
            MODE_SMUL: begin is_signed = 1'b1; is_accum = 1'b0; end
            MODE_UMAC: begin is_signed = 1'b0; is_accum = 1'b1; end
            MODE_SMAC: begin is_signed = 1'b1; is_accum = 1'b1; end
            default:   begin is_signed = 1'b0; is_accum = 1'b0; end
        endcase
    end

    assign fire = wr_en && (addr == AW'(OFS_TRIGGER));

    // R1: a signed-accumulate load lands in the matching state with the operand
    a_r1_load_smac: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFS_LOAD_SMAC)) |=> (mode == MODE_SMAC && op1 == $past(wr_data)));

    // R8: a trigger write keeps mode and operand 1
    a_r8_trigger_keeps_op1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ($stable(mode) && $stable(op1)));
endmodule

// File: rtl/mac_core.sv
module mac_core
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            is_signed,
    input  logic            is_accum,
    input  logic [DW-1:0]   op1,
    input  logic [DW-1:0]   op2,
    output logic [2*DW-1:0] prod_q,
    output logic [2*DW-1:0] acc_q
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] a_w, b_w, prod;

    assign a_w  = is_signed ? {{DW{op1[DW-1]}}, op1} : {{DW{1'b0}}, op1};
    assign b_w  = is_signed ? {{DW{op2[DW-1]}}, op2} : {{DW{1'b0}}, op2};
    assign prod = a_w * b_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            acc_q  <= '0;
        end else if (fire) begin
            if (is_accum) begin
                acc_q  <= acc_q + prod;
                prod_q <= '0;
            end else begin
                prod_q <= prod;
                acc_q  <= '0;
            end
        end
    end

    // R4: a multiply leaves the accumulator empty
    a_r4_mul_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !is_accum) |=> (acc_q == '0));

    // R5: an accumulate leaves the product register empty
    a_r5_mac_clears_prod: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_accum) |=> (prod_q == '0));

    // R10: without a trigger, neither result register moves
    a_r10_hold_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(prod_q) && $stable(acc_q)));
endmodule

// File: rtl/mac_readback.sv
module mac_readback
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic            is_signed,
    input  logic            is_accum,
    input  logic [2*DW-1:0] prod_q,
    input  logic [2*DW-1:0] acc_q,
    output logic [DW-1:0]   rd_data
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] view;
    logic [DW-1:0] rd_nxt;

    assign view = is_accum ? acc_q : prod_q;

    always_comb begin
        if (addr == AW'(OFS_RES_LO))
            rd_nxt = view[DW-1:0];
        else if (addr == AW'(OFS_RES_HI))
            rd_nxt = view[PW-1:DW];
        else if (addr == AW'(OFS_SIGN))
            rd_nxt = (is_signed && view[PW-1]) ? '1 : '0;
        else
            rd_nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_nxt;
    end

    // R7: the sign word is all-zero or all-one
    a_r7_sign_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(OFS_SIGN)) |=> (rd_data == '0 || rd_data == '1));

    // R7: unsigned modes never report a negative value
    a_r7_unsigned_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(OFS_SIGN) && !is_signed) |=> (rd_data == '0));

    // R6: read data holds between strobes
    a_r6_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/mac_periph.sv
module mac_periph
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int PW = 2 * DW;

    mac_mode_t     mode;
    logic [DW-1:0] op1;
    logic          fire, is_signed, is_accum;
    logic [PW-1:0] prod_q, acc_q;

    mac_mode_ctl #(.DW(DW), .AW(AW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .mode(mode), .op1(op1), .fire(fire), .is_signed(is_signed), .is_accum(is_accum)
    );

    mac_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .fire(fire), .is_signed(is_signed), .is_accum(is_accum),
        .op1(op1), .op2(wr_data), .prod_q(prod_q), .acc_q(acc_q)
    );

    mac_readback #(.DW(DW), .AW(AW)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .is_signed(is_signed), .is_accum(is_accum),
        .prod_q(prod_q), .acc_q(acc_q), .rd_data(rd_data)
    );

    // R9: leaving reset starts in unsigned multiply with empty registers
    a_r9_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (mode == MODE_UMUL && op1 == '0 && prod_q == '0 && acc_q == '0));
endmodule

// File: tb/test_mac_periph.sv
module test_mac_periph;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int          m_mode = 0;
    int          m_op1 = 0;
    longint      m_prod = 0;
    longint      m_acc = 0;
    logic [15:0] exp_rd = '0;

    mac_periph i_mac_periph (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint sx16(input int v, input bit sgn);
        if (sgn && v >= 32768) return longint'(v) - 65536;
        return longint'(v);
    endfunction

    function automatic logic [15:0] model_read(input int a);
        longint v;
        bit sgn;
        sgn = (m_mode == 1 || m_mode == 3);
        v = (m_mode >= 2) ? m_acc : m_prod;
        if (a == 'h13A) return v[15:0];
        if (a == 'h13C) return v[31:16];
        if (a == 'h13E) return (sgn && v[31]) ? 16'hFFFF : 16'h0000;
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_op1 = 0; m_prod = 0; m_acc = 0; exp_rd = '0;
        end else begin
            if (rd_en) exp_rd = model_read(int'(addr));
            if (wr_en) begin
                case (int'(addr))
                    'h130: begin m_mode = 0; m_op1 = int'(wr_data); end
                    'h132: begin m_mode = 1; m_op1 = int'(wr_data); end
                    'h134: begin m_mode = 2; m_op1 = int'(wr_data); end
                    'h136: begin m_mode = 3; m_op1 = int'(wr_data); end
                    'h138: begin
                        longint p;
                        bit sgn;
                        sgn = (m_mode == 1 || m_mode == 3);
                        p = sx16(m_op1, sgn) * sx16(int'(wr_data), sgn);
                        if (m_mode >= 2) begin
                            m_acc = (m_acc + p) & 64'hFFFF_FFFF;
                            m_prod = 0;
                        end else begin
                            m_prod = p & 64'hFFFF_FFFF;
                            m_acc = 0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: every cycle, rd_data must match the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL R6 per-cycle rd_data actual=%h expected=%h", rd_data, exp_rd);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus(input bit w, input bit r, input int a, input int d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = 9'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(input int a, input int d);
        bus(1, 0, a, d);
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string tag);
        bus(0, 1, a, 0);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s offset=%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        rd_chk('h13A, 16'h0000, "R9");
        rd_chk('h13C, 16'h0000, "R9");
        rd_chk('h13E, 16'h0000, "R9");

        // R1 R2: unsigned multiply
        wr('h130, 'hFFFF); wr('h138, 'hFFFF);
        rd_chk('h13A, 16'h0001, "R2");
        rd_chk('h13C, 16'hFFFE, "R1");
        rd_chk('h13E, 16'h0000, "R7");

        // R3: signed multiply, -1 * 3
        wr('h132, 'hFFFF); wr('h138, 'h0003);
        rd_chk('h13A, 16'hFFFD, "R3");
        rd_chk('h13C, 16'hFFFF, "R3");
        rd_chk('h13E, 16'hFFFF, "R7");
        wr('h132, 'h8000); wr('h138, 'h8000);
        rd_chk('h13C, 16'h4000, "R3");
        rd_chk('h13E, 16'h0000, "R7");

        // R5 R8: unsigned accumulate, repeated trigger
        wr('h134, 'h0002); wr('h138, 'h0003);
        rd_chk('h13A, 16'h0006, "R5");
        wr('h138, 'h0004);
        rd_chk('h13A, 16'h000E, "R8");
        wr('h130, 'h0005);
        rd_chk('h13A, 16'h0000, "R5");

        // R5: signed accumulate crossing zero
        wr('h136, 'hFFFF); wr('h138, 'h0002);
        rd_chk('h13A, 16'h000C, "R5");
        wr('h138, 'h0010);
        rd_chk('h13A, 16'hFFFC, "R5");
        rd_chk('h13C, 16'hFFFF, "R5");
        rd_chk('h13E, 16'hFFFF, "R7");
        wr('h134, 'h0001); wr('h138, 'h0001);
        rd_chk('h13C, 16'hFFFF, "R5");
        rd_chk('h13E, 16'h0000, "R7");

        // R4: multiply clears accumulator
        wr('h130, 'h0003); wr('h138, 'h0004);
        rd_chk('h13A, 16'h000C, "R4");
        wr('h134, 'h0000);
        rd_chk('h13A, 16'h0000, "R4");
        rd_chk('h13C, 16'h0000, "R4");

        // R10: stray writes and reads
        wr('h130, 'h0007); wr('h138, 'h0006);
        wr('h13A, 'h1234); wr('h100, 'hFFFF); wr('h13E, 'h5555);
        rd_chk('h13A, 16'h002A, "R10");
        rd_chk('h130, 16'h0000, "R10");
        rd_chk('h100, 16'h0000, "R10");

        // random traffic, checked each cycle against the model
        for (int i = 0; i < 400; i++) begin
            int a;
            bit w, r;
            a = ($urandom % 10 == 0) ? 'h120 : ('h130 + 2 * ($urandom % 8));
            w = $urandom % 2;
            r = $urandom % 2;
            bus(w, r, a, $urandom % 65536);
        end

        // R9: reset mid-run
        wr('h136, 'h0009); wr('h138, 'h0009);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_chk('h13A, 16'h0000, "R9");
        wr('h138, 'h0005);
        rd_chk('h13A, 16'h0000, "R9");
        rd_chk('h13E, 16'h0000, "R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule